// File: doc/BRIEF.md
# Parallel Panel Timing Generator

This block produces the raster timing for a parallel RGB panel from configuration words. The words set the visible size, the porches and the sync pulse widths. It runs on the pixel clock and counts pixels across each line and lines down each frame. From those counts it drives horizontal and vertical sync, a data-enable, a composite-blank signal and the current pixel coordinates. Each line and each frame runs in this order: visible region, front porch, sync pulse, back porch.

A control word selects the following:
- whether the raster runs at all;
- the level each sync is asserted at;
- the level composite blank is asserted at;
- whether downstream logic should sample on the inverted pixel clock;
- a panel mode. In the blanking mode, data-enable is forced off and composite blank is held asserted, while the syncs keep running.

Two event outputs are provided. A one-cycle trigger marks the asserting edge of vertical sync, so that a frame fetch can be started. A frame-done status bit rises when the last visible pixel of a frame is output; software clears it by writing a zero to it.

Top module: `panel_timing_gen`

## Requirements
- R1: `total_size` equals the vertical total in bits 31:16 and the horizontal total in bits 15:0. Each total is visible + front porch + sync width + back porch. The horizontal fields are: `cfg_active[15:0]` pixels, `cfg_hporch[15:0]` front porch, `cfg_hporch[31:16]` back porch, `cfg_sync[15:0]` sync width. The vertical fields use bits 31:16 of `cfg_active` for lines and bits 31:16 of `cfg_sync` for sync width, and `cfg_vporch` for the porches with the same front/back split as `cfg_hporch`. Totals up to 2048 are supported.
- R2: `pix_x` counts 0 to htotal-1 and then wraps. The horizontal sync is asserted exactly while `pix_x` lies in [visible+front, visible+front+sync).
- R3: `pix_y` advances when `pix_x` wraps and counts 0 to vtotal-1. The vertical sync is asserted for whole lines whose `pix_y` lies in [visible+front, visible+front+sync).
- R4: `de` is high exactly when `pix_x` < visible pixels and `pix_y` < visible lines, unless the panel is in blanking mode.
- R5: When `cfg_ctrl[2]` is 1, `hsync` is asserted low; when it is 0, `hsync` is asserted high. `cfg_ctrl[3]` sets the `vsync` level in the same way.
- R6: `dma_trig` pulses for one cycle on the first cycle of each frame in which `vsync` sits at its asserted level. With active-low sync this is the falling edge; with active-high sync it is the rising edge.
- R7: `frame_irq` becomes 1 in the cycle in which the outputs show the last visible pixel of the frame.
- R8: A cycle with `irq_wr`=1 and `irq_wdata`=0 clears `frame_irq` on the next cycle. A write of 1 leaves it unchanged. A clear that coincides with a new frame-done event loses, and the bit stays set.
- R9: While `cfg_ctrl[0]` is 0, the counters are held at 0. From the first clock edge after the bit is cleared, the outputs show `de`=0, both syncs at their inactive levels, `dma_trig`=0 and composite blank asserted. After the bit is set, the outputs after the n-th clock edge show position n counted from (0,0).
- R10: When `cfg_ctrl[31:28]` equals 7, `de` stays 0 and composite blank stays asserted, while the syncs, counters and `dma_trig` continue unchanged.
- R11: `cblank` is asserted whenever `de` would be low. It is asserted high when `cfg_ctrl[5]` is 1 and low when it is 0. `pclk_inv` follows `cfg_ctrl[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ctrl | input | 32 | Enable, polarities, clock inversion, panel mode |
| cfg_active | input | 32 | Visible lines [31:16], visible pixels [15:0] |
| cfg_hporch | input | 32 | Horizontal back porch [31:16], front porch [15:0] |
| cfg_vporch | input | 32 | Vertical back porch [31:16], front porch [15:0] |
| cfg_sync | input | 32 | Vertical sync lines [31:16], horizontal sync pixels [15:0] |
| irq_wr | input | 1 | Write strobe for the frame-done status bit |
| irq_wdata | input | 1 | Value written; 0 clears the status |
| total_size | output | 32 | Vertical total [31:16], horizontal total [15:0] |
| hsync | output | 1 | Horizontal sync at the programmed level |
| vsync | output | 1 | Vertical sync at the programmed level |
| de | output | 1 | Data enable |
| cblank | output | 1 | Composite blank at the programmed level |
| pclk_inv | output | 1 | Pixel clock inversion select |
| pix_x | output | 12 | Horizontal position within the line |
| pix_y | output | 12 | Vertical position within the frame |
| dma_trig | output | 1 | One-cycle frame fetch trigger |
| frame_irq | output | 1 | Frame-done status |

## Verification
The hardest case to reach is a software clear that lands in the same cycle as a new frame-done event. Reaching it needs the write strobe aligned to one specific pixel of a running frame. The bench counts clock edges from the moment it enables the raster, and from that count it knows the exact edge at which the last visible pixel of the second frame appears; it drives the clear for that edge. The other polarity and blanking combinations are swept over whole frames of a small raster, and every output is compared on every cycle against positions the bench computes arithmetically.

// File: rtl/ptg_pkg.sv
// Shared definitions for the panel timing generator.
// Holds the control-word bit positions and the decoded control record.
package ptg_pkg;
    localparam int FIELD_W   = 16;
    localparam int EN_BIT    = 0;
    localparam int PCLK_BIT  = 1;
    localparam int HSLOW_BIT = 2;
    localparam int VSLOW_BIT = 3;
    localparam int CBHI_BIT  = 5;
    localparam int MODE_LSB  = 28;
    localparam logic [3:0] MODE_BLANKED = 4'd7;

    typedef struct packed {
        logic enable;
        logic pclk_inv;
        logic hs_low;
        logic vs_low;
        logic cb_high;
        logic blanked;
    } ptg_ctrl_t;
endpackage

// File: rtl/ptg_axis_counter.sv
// One raster axis counter: counts 0..total-1 while enabled and stepping.
// Assumes total >= 1 and that total is held constant while enabled.
module ptg_axis_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Last position of the axis reached on a stepping cycle.
    assign wrap = step && (cnt == total - ONE);

    // Advance, wrap, or hold at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (step)
            cnt <= wrap ? '0 : cnt + ONE;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (total != '0) |-> (cnt < total));
endmodule

// File: rtl/ptg_phase_decode.sv
// Region decode for one axis: visible, then front porch, sync, back porch.
// Assumes the region sums do not overflow the field width.
module ptg_phase_decode #(
    parameter int CNT_W   = 12,
    parameter int FIELD_W = 16
) (
    input  logic [CNT_W-1:0]   cnt,
    input  logic [FIELD_W-1:0] act,
    input  logic [FIELD_W-1:0] fp,
    input  logic [FIELD_W-1:0] sw,
    output logic               in_active,
    output logic               in_sync
);
    localparam int PAD = FIELD_W - CNT_W;

    logic [FIELD_W-1:0] pos, sync_start, sync_end;

    // Widen the count and locate the sync window.
    always_comb begin
        pos        = {{PAD{1'b0}}, cnt};
        sync_start = act + fp;
        sync_end   = sync_start + sw;
        in_active  = pos < act;
        in_sync    = (pos >= sync_start) && (pos < sync_end);
    end
endmodule

// File: rtl/ptg_out_stage.sv
// Output register stage: aligns syncs, data-enable, blank and coordinates,
// applies pin polarities and forms the vsync-assertion trigger.
// Assumes polarity selects change only while the raster is disabled.
module ptg_out_stage #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hs_next,
    input  logic             vs_next,
    input  logic             de_next,
    input  logic [CNT_W-1:0] x_next,
    input  logic [CNT_W-1:0] y_next,
    input  logic             hs_low,
    input  logic             vs_low,
    input  logic             cb_high,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             cblank,
    output logic             dma_trig,
    output logic [CNT_W-1:0] pix_x,
    output logic [CNT_W-1:0] pix_y
);
    logic hs_q, vs_q, cb_q;

    // Register the decoded raster state, or park it while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hs_q     <= 1'b0;
            vs_q     <= 1'b0;
            de       <= 1'b0;
            cb_q     <= 1'b1;
            dma_trig <= 1'b0;
            pix_x    <= '0;
            pix_y    <= '0;
        end else begin
            hs_q     <= hs_next;
            vs_q     <= vs_next;
            de       <= de_next;
            cb_q     <= !de_next;
            dma_trig <= vs_next && !vs_q;
            pix_x    <= x_next;
            pix_y    <= y_next;
        end
    end

    // Apply the programmed assertion levels at the pins.
    assign hsync  = hs_q ^ hs_low;
    assign vsync  = vs_q ^ vs_low;
    assign cblank = cb_q ^ !cb_high;

    // R6
    dma_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_trig && $stable(vs_low)) |-> ((vsync == !vs_low) && ($past(vsync) == vs_low)));
    // R9
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!de && !dma_trig && pix_x == '0 && pix_y == '0));
endmodule

// File: rtl/ptg_irq_status.sv
// Frame-done status bit: set by the raster event, cleared by writing zero.
// A set in the same cycle as a clear takes priority.
module ptg_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic wr,
    input  logic wdata,
    output logic status
);
    logic clr;
    assign clr = wr && !wdata;

    // Hold, set on the event, or clear on a zero write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= 1'b0;
        else if (set)
            status <= 1'b1;
        else if (clr)
            status <= 1'b0;
    end

    // R7
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> status);
    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !status);
    // R8
    status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr) |=> status);
endmodule

// File: rtl/panel_timing_gen.sv
// Parallel panel timing generator top.
// Counts pixels and lines on the pixel clock and derives sync, data-enable,
// composite blank, the frame fetch trigger and the frame-done status.
// Assumes each total stays within MAX_TOTAL and config is static while enabled.
module panel_timing_gen
    import ptg_pkg::*;
#(
    parameter int  MAX_TOTAL = 2048,
    localparam int CNT_W     = $clog2(MAX_TOTAL) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cfg_ctrl,
    input  logic [31:0]      cfg_active,
    input  logic [31:0]      cfg_hporch,
    input  logic [31:0]      cfg_vporch,
    input  logic [31:0]      cfg_sync,
    input  logic             irq_wr,
    input  logic             irq_wdata,
    output logic [31:0]      total_size,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             cblank,
    output logic             pclk_inv,
    output logic [CNT_W-1:0] pix_x,
    output logic [CNT_W-1:0] pix_y,
    output logic             dma_trig,
    output logic             frame_irq
);
    localparam int PAD = FIELD_W - CNT_W;
    localparam logic [FIELD_W-1:0] ONE16 = {{(FIELD_W-1){1'b0}}, 1'b1};

    ptg_ctrl_t ctrl;
    logic unused_ctrl_bits;

    // Decode the control word.
    always_comb begin
        ctrl.enable   = cfg_ctrl[EN_BIT];
        ctrl.pclk_inv = cfg_ctrl[PCLK_BIT];
        ctrl.hs_low   = cfg_ctrl[HSLOW_BIT];
        ctrl.vs_low   = cfg_ctrl[VSLOW_BIT];
        ctrl.cb_high  = cfg_ctrl[CBHI_BIT];
        ctrl.blanked  = cfg_ctrl[MODE_LSB +: 4] == MODE_BLANKED;
    end
    assign unused_ctrl_bits = ^{cfg_ctrl[27:6], cfg_ctrl[4]};
    assign pclk_inv = ctrl.pclk_inv;

    // Per-axis fields, index 0 horizontal, index 1 vertical.
    logic [1:0][FIELD_W-1:0] act_a, fp_a, sw_a, bp_a, tot_a;
    logic [1:0][CNT_W-1:0]   cnt_a;
    logic [1:0]              step_a, wrap_a, in_act_a, in_sync_a;

    assign act_a = {cfg_active[31:16], cfg_active[15:0]};
    assign fp_a  = {cfg_vporch[15:0],  cfg_hporch[15:0]};
    assign bp_a  = {cfg_vporch[31:16], cfg_hporch[31:16]};
    assign sw_a  = {cfg_sync[31:16],   cfg_sync[15:0]};
    assign step_a = {wrap_a[0], 1'b1};

    genvar ax;
    generate
        for (ax = 0; ax < 2; ax++) begin : g_axis
            // Total of one axis from its four regions.
            assign tot_a[ax] = act_a[ax] + fp_a[ax] + sw_a[ax] + bp_a[ax];

            ptg_axis_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (ctrl.enable),
                .step  (step_a[ax]),
                .total (tot_a[ax][CNT_W-1:0]),
                .cnt   (cnt_a[ax]),
                .wrap  (wrap_a[ax])
            );

            ptg_phase_decode #(.CNT_W(CNT_W), .FIELD_W(FIELD_W)) u_dec (
                .cnt       (cnt_a[ax]),
                .act       (act_a[ax]),
                .fp        (fp_a[ax]),
                .sw        (sw_a[ax]),
                .in_active (in_act_a[ax]),
                .in_sync   (in_sync_a[ax])
            );
        end
    endgenerate

    assign total_size = {tot_a[1], tot_a[0]};

    logic de_next, frame_done;

    // Visible-pixel and last-visible-pixel decode.
    always_comb begin
        de_next    = in_act_a[0] && in_act_a[1] && !ctrl.blanked;
        frame_done = ctrl.enable
                     && ({{PAD{1'b0}}, cnt_a[0]} == act_a[0] - ONE16)
                     && ({{PAD{1'b0}}, cnt_a[1]} == act_a[1] - ONE16);
    end

    ptg_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl.enable),
        .hs_next  (in_sync_a[0]),
        .vs_next  (in_sync_a[1]),
        .de_next  (de_next),
        .x_next   (cnt_a[0]),
        .y_next   (cnt_a[1]),
        .hs_low   (ctrl.hs_low),
        .vs_low   (ctrl.vs_low),
        .cb_high  (ctrl.cb_high),
        .hsync    (hsync),
        .vsync    (vsync),
        .de       (de),
        .cblank   (cblank),
        .dma_trig (dma_trig),
        .pix_x    (pix_x),
        .pix_y    (pix_y)
    );

    ptg_irq_status u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (frame_done),
        .wr     (irq_wr),
        .wdata  (irq_wdata),
        .status (frame_irq)
    );

    // R4
    de_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (({{PAD{1'b0}}, pix_x} < act_a[0]) && ({{PAD{1'b0}}, pix_y} < act_a[1])));
    // R10
    blank_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl.blanked) |-> !de);
endmodule

// File: tb/panel_timing_gen_bench.sv
`timescale 1ns/1ps
module panel_timing_gen_bench;
    localparam int HA = 6, HF = 2, HS = 3, HB = 1, HT = 12;
    localparam int VA = 4, VF = 1, VS = 2, VB = 2, VT = 9;
    localparam int FR = HT * VT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_ctrl = 32'h0;
    logic [31:0] cfg_active, cfg_hporch, cfg_vporch, cfg_sync;
    logic        irq_wr = 1'b0, irq_wdata = 1'b0;
    logic [31:0] total_size;
    logic        hsync, vsync, de, cblank, pclk_inv, dma_trig, frame_irq;
    logic [11:0] pix_x, pix_y;

    int n_chk = 0, n_err = 0;
    int exp_irq = 0;

    always #10 clk = ~clk;

    panel_timing_gen u_panel_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_active(cfg_active),
        .cfg_hporch(cfg_hporch), .cfg_vporch(cfg_vporch), .cfg_sync(cfg_sync),
        .irq_wr(irq_wr), .irq_wdata(irq_wdata), .total_size(total_size),
        .hsync(hsync), .vsync(vsync), .de(de), .cblank(cblank),
        .pclk_inv(pclk_inv), .pix_x(pix_x), .pix_y(pix_y),
        .dma_trig(dma_trig), .frame_irq(frame_irq)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Idle outputs after the raster has been disabled (R9).
    task automatic check_idle(input logic [31:0] c);
        check("R9", "pix_x idle", pix_x, 0);
        check("R9", "pix_y idle", pix_y, 0);
        check("R9", "de idle", de, 0);
        check("R9", "hsync idle", hsync, c[2]);
        check("R9", "vsync idle", vsync, c[3]);
        check("R9", "cblank idle", cblank, c[5]);
        check("R9", "dma idle", dma_trig, 0);
    endtask

    // Run the raster for whole frames and compare every cycle.
    task automatic sweep(input logic [31:0] c, input int frames, input int clr_k);
        int blk;
        blk = (c[31:28] == 4'd7) ? 1 : 0;
        @(negedge clk);
        irq_wr = 1'b1; irq_wdata = 1'b0;
        @(negedge clk);
        irq_wr = 1'b0;
        exp_irq = 0;
        check("R8", "irq cleared before sweep", frame_irq, 0);
        cfg_ctrl = c | 32'h1;
        for (int k = 0; k < frames * FR; k++) begin
            int x, y, de_e, hs_e, vs_e;
            irq_wr = (k == clr_k); irq_wdata = 1'b0;
            @(posedge clk);
            @(negedge clk);
            x = k % HT;
            y = (k / HT) % VT;
            de_e = (x < HA && y < VA && blk == 0) ? 1 : 0;
            hs_e = (x >= HA + HF && x < HA + HF + HS) ? 1 : 0;
            vs_e = (y >= VA + VF && y < VA + VF + VS) ? 1 : 0;
            if (x == HA - 1 && y == VA - 1) exp_irq = 1;
            check("R2", "pix_x", pix_x, x);
            check("R3", "pix_y", pix_y, y);
            check(blk ? "R10" : "R4", "de", de, de_e);
            check("R5", "hsync", hsync, hs_e ^ c[2]);
            check("R5", "vsync", vsync, vs_e ^ c[3]);
            check("R11", "cblank", cblank, (de_e == 0) ? c[5] : !c[5]);
            check("R6", "dma_trig", dma_trig, (x == 0 && y == VA + VF) ? 1 : 0);
            check("R7", "frame_irq", frame_irq, exp_irq);
        end
        irq_wr = 1'b0;
        check("R11", "pclk_inv", pclk_inv, c[1]);
        cfg_ctrl = c & ~32'h1;
        @(negedge clk);
        check_idle(c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        cfg_active = {16'(VA), 16'(HA)};
        cfg_hporch = {16'(HB), 16'(HF)};
        cfg_vporch = {16'(VB), 16'(VF)};
        cfg_sync   = {16'(VS), 16'(HS)};
        repeat (3) @(negedge clk);
        // Reset state with active-high syncs and active-low blank.
        check("R9", "reset de", de, 0);
        check("R9", "reset hsync", hsync, 0);
        check("R9", "reset vsync", vsync, 0);
        check("R11", "reset cblank", cblank, 0);
        check("R7", "reset irq", frame_irq, 0);
        check("R1", "total_size", total_size, {16'(VT), 16'(HT)});
        rst_n = 1'b1;
        @(negedge clk);
        check_idle(32'h0);

        // Active-high syncs; a clear coincides with the second frame-done (R8).
        sweep(32'h0000_0001, 2, FR + (VA - 1) * HT + HA - 1);
        check("R8", "set wins over clear", frame_irq, 1);
        irq_wr = 1'b1; irq_wdata = 1'b1;
        @(negedge clk);
        irq_wr = 1'b0;
        check("R8", "write one keeps", frame_irq, 1);
        irq_wr = 1'b1; irq_wdata = 1'b0;
        @(negedge clk);
        irq_wr = 1'b0;
        check("R8", "write zero clears", frame_irq, 0);

        // All active-low, blank active-high, clock inverted.
        sweep(32'h0000_002F, 1, -1);
        // Blanking mode keeps timing running.
        sweep(32'h7000_0001, 1, -1);
        // Mixed polarity.
        sweep(32'h0000_0025, 1, -1);

        summary();
        $finish;
    end
endmodule